// File: doc/BRIEF.md
# Packed Byte-to-Element Vector Transfer

This unit moves up to eight bytes between a 16-byte line of scratch memory and the eight 16-bit elements of a vector register. Each byte becomes one fixed-point field of an element, and each element field becomes one byte. A request gives a mode subfield, a direction, a 4-bit element index, a signed 7-bit offset and a base address. The unit scales the offset, adds the base, and selects the memory line. Inside that line it picks byte positions from the address and the element index.

The unit asks for the line combinationally and takes the line data in the same cycle. One cycle after the request it presents a registered result. A load returns the complete new register value. A store returns the line index, sixteen byte enables and the byte data. The register read port and the write-back path belong to the surrounding datapath.

There are four modes. Pack uses the top byte of an element. Unpack uses bits 14:7. Half is unpack with a 2-byte stride. Fourth is unpack with a 4-byte stride and serves only one half of the register.

Top module: `byte_elem_xfer`

## Requirements
- R1: While rst_ni is low, and afterwards until the first accepted request, ld_valid_o and st_valid_o are 0 and all data, address and enable outputs are 0.
- R2: A request is accepted only when req_i is 1 and sub_i is 6 (pack), 7 (unpack), 8 (half) or 9 (fourth). store_i = 1 selects a store and 0 selects a load. Any other sub_i value raises neither valid output in the next cycle.
- R3: The offset off_i is a signed 7-bit value. The byte address is base_i + off*8 for pack and unpack, and base_i + off*16 for half and fourth, taken modulo 2^AW. rd_addr_o shows the line index (address >> 4) combinationally in the request cycle. Below, a is address[3:0] and e is elem_i.
- R4: Line byte p occupies bits 8p+7:8p of a line. Element i occupies bits 16i+15:16i of a register. A pack load sets element i to {byte at position (a + 16 - e + i) mod 16, 8'h00}.
- R5: An unpack load sets element i to the byte at position (a + 16 - e + i) mod 16, shifted left by 7. All other bits of the element are 0.
- R6: A half load sets element i to the byte at position (a + 16 - e + 2i) mod 16, shifted left by 7.
- R7: A fourth load uses h = e[3]. It sets element 4h + j (j = 0..3) to the byte at position (a + 4j) mod 16, shifted left by 7. The other four elements take their value from vreg_i.
- R8: For an accepted load, ld_valid_o is 1 in the next cycle and ld_data_o holds the result. st_valid_o stays 0.
- R9: A pack store writes bits 15:8 of element i to line position (a + 16 - e + i) mod 16 and sets the enable bit for that position.
- R10: An unpack store writes bits 14:7 of element i to position (a + 16 - e + i) mod 16. A half store writes the same bits to position (a + 16 - e + 2i) mod 16.
- R11: A fourth store writes bits 14:7 of element 4h + j to position (a + 4j) mod 16, with h = e[3]. Exactly four enable bits are set.
- R12: For an accepted store, st_valid_o is 1 in the next cycle and st_addr_o holds the line index. Byte lanes whose enable bit is 0 read 0 in st_line_o. ld_valid_o stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe |
| sub_i | input | 5 | Mode subfield, 6 to 9 valid |
| store_i | input | 1 | 1 = store, 0 = load |
| elem_i | input | 4 | Element index |
| off_i | input | 7 | Signed offset |
| base_i | input | AW (12) | Base byte address |
| vreg_i | input | 128 | Current register value |
| rd_addr_o | output | AW-4 (8) | Line index to read |
| rd_line_i | input | 128 | Line data for rd_addr_o |
| ld_valid_o | output | 1 | Load result valid |
| ld_data_o | output | 128 | New register value |
| st_valid_o | output | 1 | Store data valid |
| st_addr_o | output | AW-4 (8) | Line index to write |
| st_be_o | output | 16 | Byte enables |
| st_line_o | output | 128 | Byte data for the line |

## Verification
A behavioural model predicts every output on every cycle. Directed requests come first and are followed by a long random stream.

- **Element index 0 and 15.** These separate the wrap of the position sum modulo 16 from a plain byte offset.
- **Negative offsets near base 0.** These exercise the wrap of the address space and the two different offset scales.
- **Fourth mode with e[3] set and clear.** These show which half of the register is replaced and which half is kept.
- **Sub values 5, 10, 0 and 31, plus idle cycles between requests.** These show that rejected requests raise no valid output.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef enum logic [1:0] {
    XM_PACK   = 2'd0,
    XM_UNPACK = 2'd1,
    XM_HALF   = 2'd2,
    XM_FOURTH = 2'd3
  } xfer_mode_e;

  localparam logic [4:0] SUB_BASE = 5'd6;
  localparam logic [4:0] SUB_LAST = 5'd9;
endpackage

// File: rtl/xfer_addr.sv
module xfer_addr
  import xfer_pkg::*;
#(
  parameter int AW = 12,
  parameter int PW = 4
) (
  input  xfer_mode_e       mode_i,
  input  logic [6:0]       off_i,
  input  logic [AW-1:0]    base_i,
  output logic [AW-PW-1:0] line_o,
  output logic [PW-1:0]    pos_o
);
  logic [AW-1:0] off_ext, scaled, addr;
  logic          wide;

  assign off_ext = {{(AW-7){off_i[6]}}, off_i};
  // half and fourth step whole lines, pack and unpack step half lines
  assign wide    = (mode_i == XM_HALF) || (mode_i == XM_FOURTH);
  assign scaled  = wide ? (off_ext << PW) : (off_ext << (PW-1));
  assign addr    = base_i + scaled;
  assign line_o  = addr[AW-1:PW];
  assign pos_o   = addr[PW-1:0];
endmodule

// File: rtl/xfer_map.sv
module xfer_map
  import xfer_pkg::*;
#(
  parameter int NE = 8,
  parameter int PW = $clog2(2*NE)
) (
  input  xfer_mode_e            mode_i,
  input  logic [PW-1:0]         pos_i,
  input  logic [PW-1:0]         elem_i,
  output logic [NE-1:0][PW-1:0] epos_o,
  output logic [NE-1:0]         eact_o
);
  localparam int GW = NE / 2;

  for (genvar gi = 0; gi < NE; gi++) begin : g_el
    localparam logic [PW-1:0] STEP1 = PW'(gi);
    localparam logic [PW-1:0] STEP2 = PW'(2*gi);
    localparam logic [PW-1:0] STEP4 = PW'(4*(gi % GW));
    localparam bit            GRP   = (gi >= GW);

    always_comb begin
      unique case (mode_i)
        XM_HALF:   epos_o[gi] = pos_i - elem_i + STEP2;
        XM_FOURTH: epos_o[gi] = pos_i + STEP4;
        default:   epos_o[gi] = pos_i - elem_i + STEP1;
      endcase
      eact_o[gi] = (mode_i != XM_FOURTH) || (elem_i[PW-1] == GRP);
    end
  end
endmodule

// File: rtl/xfer_load.sv
module xfer_load
  import xfer_pkg::*;
#(
  parameter int NE = 8,
  parameter int PW = $clog2(2*NE)
) (
  input  xfer_mode_e            mode_i,
  input  logic [16*NE-1:0]      line_i,
  input  logic [16*NE-1:0]      vreg_i,
  input  logic [NE-1:0][PW-1:0] epos_i,
  input  logic [NE-1:0]         eact_i,
  output logic [16*NE-1:0]      data_o
);
  for (genvar gi = 0; gi < NE; gi++) begin : g_el
    logic [7:0]  b;
    logic [15:0] field;
    assign b     = line_i[{epos_i[gi], 3'b000} +: 8];
    assign field = (mode_i == XM_PACK) ? {b, 8'h00} : {1'b0, b, 7'h00};
    assign data_o[16*gi +: 16] = eact_i[gi] ? field : vreg_i[16*gi +: 16];
  end
endmodule

// File: rtl/xfer_store.sv
module xfer_store
  import xfer_pkg::*;
#(
  parameter int NE = 8,
  parameter int PW = $clog2(2*NE)
) (
  input  xfer_mode_e            mode_i,
  input  logic [16*NE-1:0]      vreg_i,
  input  logic [NE-1:0][PW-1:0] epos_i,
  input  logic [NE-1:0]         eact_i,
  output logic [16*NE-1:0]      line_o,
  output logic [2*NE-1:0]       be_o
);
  logic [NE-1:0][7:0] ebyte;

  for (genvar gi = 0; gi < NE; gi++) begin : g_el
    assign ebyte[gi] = (mode_i == XM_PACK) ? vreg_i[16*gi+8 +: 8] : vreg_i[16*gi+7 +: 8];
  end

  // positions are distinct within any one mode, so lanes never collide
  always_comb begin
    line_o = '0;
    be_o   = '0;
    for (int i = 0; i < NE; i++) begin
      if (eact_i[i]) begin
        line_o[{epos_i[i], 3'b000} +: 8] = ebyte[i];
        be_o[epos_i[i]] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/byte_elem_xfer.sv
module byte_elem_xfer
  import xfer_pkg::*;
#(
  parameter int AW = 12,
  parameter int NE = 8,
  localparam int PW = $clog2(2*NE),
  localparam int LW = AW - PW,
  localparam int VW = 16*NE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [4:0]    sub_i,
  input  logic          store_i,
  input  logic [PW-1:0] elem_i,
  input  logic [6:0]    off_i,
  input  logic [AW-1:0] base_i,
  input  logic [VW-1:0] vreg_i,
  output logic [LW-1:0] rd_addr_o,
  input  logic [VW-1:0] rd_line_i,
  output logic          ld_valid_o,
  output logic [VW-1:0] ld_data_o,
  output logic          st_valid_o,
  output logic [LW-1:0] st_addr_o,
  output logic [2*NE-1:0] st_be_o,
  output logic [VW-1:0] st_line_o
);
  xfer_mode_e            mode;
  logic                  sub_ok, acc_ld, acc_st;
  logic [LW-1:0]         line;
  logic [PW-1:0]         pos;
  logic [NE-1:0][PW-1:0] epos;
  logic [NE-1:0]         eact;
  logic [VW-1:0]         ld_data, st_line;
  logic [2*NE-1:0]       st_be;
  logic [4:0]            sub_rel;

  assign sub_ok  = (sub_i >= SUB_BASE) && (sub_i <= SUB_LAST);
  assign sub_rel = sub_i - SUB_BASE;
  assign mode    = xfer_mode_e'(sub_rel[1:0]);
  assign acc_ld  = req_i && sub_ok && !store_i;
  assign acc_st  = req_i && sub_ok && store_i;

  xfer_addr #(.AW(AW), .PW(PW)) u_addr (
    .mode_i(mode), .off_i(off_i), .base_i(base_i), .line_o(line), .pos_o(pos)
  );

  xfer_map #(.NE(NE), .PW(PW)) u_map (
    .mode_i(mode), .pos_i(pos), .elem_i(elem_i), .epos_o(epos), .eact_o(eact)
  );

  xfer_load #(.NE(NE), .PW(PW)) u_load (
    .mode_i(mode), .line_i(rd_line_i), .vreg_i(vreg_i),
    .epos_i(epos), .eact_i(eact), .data_o(ld_data)
  );

  xfer_store #(.NE(NE), .PW(PW)) u_store (
    .mode_i(mode), .vreg_i(vreg_i), .epos_i(epos), .eact_i(eact),
    .line_o(st_line), .be_o(st_be)
  );

  assign rd_addr_o = line;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_valid_o <= 1'b0;
      ld_data_o  <= '0;
      st_valid_o <= 1'b0;
      st_addr_o  <= '0;
      st_be_o    <= '0;
      st_line_o  <= '0;
    end else begin
      ld_valid_o <= acc_ld;
      st_valid_o <= acc_st;
      if (acc_ld) ld_data_o <= ld_data;
      if (acc_st) begin
        st_addr_o <= line;
        st_be_o   <= st_be;
        st_line_o <= st_line;
      end
    end
  end

  assert_bad_sub_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && (sub_i < 5'd6 || sub_i > 5'd9)) |=> (!ld_valid_o && !st_valid_o));

  assert_ld_next_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !store_i && sub_i >= 5'd6 && sub_i <= 5'd9) |=> (ld_valid_o && !st_valid_o));

  assert_st_next_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && store_i && sub_i >= 5'd6 && sub_i <= 5'd9) |=> (st_valid_o && !ld_valid_o));

  assert_fourth_be_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_o && $past(sub_i == 5'd9)) |-> ($countones(st_be_o) == NE/2));

  assert_full_be_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_o && $past(sub_i != 5'd9)) |-> ($countones(st_be_o) == NE));

  for (genvar gp = 0; gp < 2*NE; gp++) begin : g_lane_chk
    assert_quiet_lane_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_valid_o && !st_be_o[gp]) |-> (st_line_o[8*gp +: 8] == 8'h00));
  end

  for (genvar ge = 0; ge < NE; ge++) begin : g_unpack_chk
    assert_unpack_field_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ld_valid_o && $past(sub_i == 5'd7)) |->
      (ld_data_o[16*ge+15] == 1'b0 && ld_data_o[16*ge +: 7] == 7'h00));
  end
endmodule

// File: tb/tb_byte_elem_xfer.sv
module tb_byte_elem_xfer;
  localparam int AW = 12;
  localparam int NE = 8;
  localparam int CLK_PERIOD = 10;
  localparam int MEMSZ = 1 << AW;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0;
  logic [4:0] sub_i = '0;
  logic store_i = 1'b0;
  logic [3:0] elem_i = '0;
  logic [6:0] off_i = '0;
  logic [AW-1:0] base_i = '0;
  logic [127:0] vreg_i = '0;
  logic [AW-5:0] rd_addr_o;
  logic [127:0] rd_line_i;
  logic ld_valid_o, st_valid_o;
  logic [127:0] ld_data_o, st_line_o;
  logic [AW-5:0] st_addr_o;
  logic [15:0] st_be_o;

  logic [7:0] mem_q [0:MEMSZ-1];

  int errors = 0;
  int checks = 0;
  bit done = 0;

  bit p_ld, p_st;
  int p_mode, p_line;
  logic [127:0] p_ld_data, p_st_line;
  logic [15:0] p_be;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always_comb begin
    for (int p = 0; p < 16; p++) rd_line_i[p*8 +: 8] = mem_q[{rd_addr_o, p[3:0]}];
  end

  byte_elem_xfer #(.AW(AW), .NE(NE)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .sub_i(sub_i), .store_i(store_i),
    .elem_i(elem_i), .off_i(off_i), .base_i(base_i), .vreg_i(vreg_i),
    .rd_addr_o(rd_addr_o), .rd_line_i(rd_line_i),
    .ld_valid_o(ld_valid_o), .ld_data_o(ld_data_o),
    .st_valid_o(st_valid_o), .st_addr_o(st_addr_o), .st_be_o(st_be_o), .st_line_o(st_line_o)
  );

  task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic string ld_tag(input int m);
    case (m)
      0: return "R4 pack load";
      1: return "R5 unpack load";
      2: return "R6 half load";
      default: return "R7 fourth load";
    endcase
  endfunction

  function automatic string st_tag(input int m);
    case (m)
      0: return "R9 pack store";
      3: return "R11 fourth store";
      default: return "R10 unpack/half store";
    endcase
  endfunction

  task automatic compare();
    chk("R8 ld_valid", 128'(ld_valid_o), 128'(p_ld));
    chk("R12 st_valid", 128'(st_valid_o), 128'(p_st));
    if (p_ld) chk(ld_tag(p_mode), ld_data_o, p_ld_data);
    if (p_st) begin
      chk("R12 st_addr", 128'(st_addr_o), 128'(p_line));
      chk({st_tag(p_mode), " enables"}, 128'(st_be_o), 128'(p_be));
      chk({st_tag(p_mode), " data"}, st_line_o, p_st_line);
    end
  endtask

  task automatic step(input bit req, input int sub, input bit st, input int elem,
                      input int off, input int base, input logic [127:0] vr);
    int m, so, addr, line, a, pos;
    bit act, ok;
    logic [15:0] v;
    @(negedge clk_i);
    compare();
    req_i = req; sub_i = 5'(sub); store_i = st; elem_i = 4'(elem);
    off_i = 7'(off); base_i = AW'(base); vreg_i = vr;
    ok = req && sub >= 6 && sub <= 9;
    m = sub - 6;
    so = (off & 127) >= 64 ? (off & 127) - 128 : (off & 127);
    addr = (base + so * ((m >= 2) ? 16 : 8)) & (MEMSZ - 1);
    line = addr >> 4;
    a = addr & 15;
    p_ld = ok && !st;
    p_st = ok && st;
    p_mode = m;
    p_line = line;
    p_ld_data = vr;
    p_st_line = '0;
    p_be = '0;
    if (ok) begin
      for (int i = 0; i < 8; i++) begin
        elem = elem & 15;
        if (m == 3) begin
          act = ((i / 4) == (elem >> 3));
          pos = (a + 4 * (i % 4)) & 15;
        end else if (m == 2) begin
          act = 1;
          pos = (a + 16 - elem + 2 * i) & 15;
        end else begin
          act = 1;
          pos = (a + 16 - elem + i) & 15;
        end
        if (act) begin
          if (!st) begin
            v = (m == 0) ? (16'(mem_q[line*16+pos]) << 8) : (16'(mem_q[line*16+pos]) << 7);
            p_ld_data[i*16 +: 16] = v;
          end else begin
            v = vr[i*16 +: 16];
            p_st_line[pos*8 +: 8] = (m == 0) ? v[15:8] : v[14:7];
            p_be[pos] = 1'b1;
          end
        end
      end
    end
    #1;
    if (ok) chk("R3 rd_addr", 128'(rd_addr_o), 128'(line));
  endtask

  function automatic logic [127:0] rnd_vec();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R8 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < MEMSZ; k++) mem_q[k] = 8'((k * 37 + 11) ^ (k >> 4));
    p_ld = 0; p_st = 0; p_mode = 0; p_line = 0;
    p_ld_data = '0; p_st_line = '0; p_be = '0;
    repeat (3) @(negedge clk_i);
    // R1: outputs quiet during reset
    chk("R1 reset ld_valid", 128'(ld_valid_o), 128'(0));
    chk("R1 reset st_valid", 128'(st_valid_o), 128'(0));
    chk("R1 reset ld_data", ld_data_o, '0);
    chk("R1 reset st_line", st_line_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after reset be", 128'(st_be_o), 128'(0));

    // directed loads
    step(1, 6, 0, 0, 0, 'h100, '0);
    step(1, 6, 0, 15, 3, 'h208, rnd_vec());
    step(1, 7, 0, 3, -2, 'h340, rnd_vec());
    step(1, 8, 0, 5, 1, 'h0, rnd_vec());
    step(1, 8, 0, 0, -1, 'h0, rnd_vec());
    step(1, 9, 0, 0, 4, 'h50, rnd_vec());
    step(1, 9, 0, 8, -64, 'h17, rnd_vec());
    // directed stores
    step(1, 6, 1, 0, 0, 'h100, rnd_vec());
    step(1, 7, 1, 9, 63, 'hff8, rnd_vec());
    step(1, 8, 1, 15, -3, 'h4, rnd_vec());
    step(1, 9, 1, 0, 2, 'h33, rnd_vec());
    step(1, 9, 1, 12, 0, 'h80, rnd_vec());
    // R2: rejected subfields
    step(1, 5, 0, 0, 0, 'h10, rnd_vec());
    step(1, 10, 1, 0, 0, 'h10, rnd_vec());
    step(1, 0, 0, 2, 1, 'h20, rnd_vec());
    step(1, 31, 1, 2, 1, 'h20, rnd_vec());
    step(0, 6, 0, 0, 0, 'h20, rnd_vec());
    step(0, 9, 1, 0, 0, 'h20, rnd_vec());

    for (int n = 0; n < 600; n++) begin
      step(($urandom % 5) != 0, 4 + int'($urandom % 8), $urandom % 2,
           int'($urandom % 16), int'($urandom % 128), int'($urandom % MEMSZ), rnd_vec());
    end
    step(0, 0, 0, 0, 0, 0, '0);
    @(negedge clk_i);
    compare();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule